// File: doc/BRIEF.md
# Software-Filled Address Translation Buffer with Clean-Page Store Trap

This block is a small fully associative translation buffer. Each lookup presents a virtual page number and a load/store flag; all entries compare their tags against it in parallel. In the same cycle, the block either returns the matching physical frame number or raises an exception code. No hardware walks page tables: when a lookup finds no valid entry, software handles the miss and installs a translation through a write port. Software chooses the entry index and sets the valid, writable and tag/frame fields.

Each entry carries a writable flag that doubles as a "page already modified" marker. A store that hits an entry with the flag clear is refused with its own exception code, so that software can record the page as dirty. Software then rewrites the same entry with the flag set and retries the store. Loads ignore the flag. Software can also remove every entry holding a given page tag in one cycle, so that no stale translation outlives an eviction.

Top module: `xlat_buffer`

## Requirements
- R1: A synchronous active-high reset clears every entry's valid flag, so every lookup after reset reports a miss until software writes an entry.
- R2: When lk_req is high and no valid entry's tag equals lk_page, lk_exc is 2'b01 (miss) and lk_frame is zero in the same cycle. The code 2'b11 never appears.
- R3: A load (lk_store low) that hits returns the entry's frame with lk_exc 2'b00, whether the writable flag is set or clear.
- R4: A store that hits an entry whose writable flag is set returns the entry's frame with lk_exc 2'b00.
- R5: A store that hits an entry whose writable flag is clear gives lk_exc 2'b10 (store to clean page) and lk_frame zero.
- R6: When several valid entries hold the same tag, the entry with the lowest index decides both the frame and the writable check.
- R7: A write through the fill port (fill_en) replaces the entry at fill_idx on the next rising clock edge. A lookup in the same cycle sees the old contents.
- R8: Rewriting an existing entry in place with the writable flag set makes a store to that page complete, where it trapped before.
- R9: inv_en clears the valid flag of every entry whose tag equals inv_page at the next edge. If the fill port writes an entry in the same cycle, the fill wins for that entry.
- R10: While lk_req is low, lk_exc is 2'b00 and lk_frame is zero, whatever the other lookup inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_store | input | 1 | Lookup is a store (1) or a load (0) |
| lk_page | input | 20 | Virtual page number to translate |
| lk_frame | output | 20 | Translated frame number, zero unless lk_exc is 00 with a request |
| lk_exc | output | 2 | 00 none, 01 miss, 10 store to clean page |
| fill_en | input | 1 | Write one entry at the next edge |
| fill_idx | input | 4 | Index of the entry to write |
| fill_valid | input | 1 | Valid flag to store |
| fill_wr_ok | input | 1 | Writable (modified) flag to store |
| fill_page | input | 20 | Tag to store |
| fill_frame | input | 20 | Frame number to store |
| inv_en | input | 1 | Invalidate every entry with tag inv_page |
| inv_page | input | 20 | Tag to invalidate |

## Verification
Several properties are checked on every cycle:
- the idle outputs;
- the absence of the unused code;
- that loads never take the clean-page trap;
- that a chosen entry truly matches and has no lower-indexed matching entry;
- that each fill lands intact at the next edge;
- that invalidation and reset leave no matching valid entry.

Other behaviour can only be shown by scenarios in the bench, which compares the outputs with a reference model:
- a lookup in the fill cycle seeing old contents;
- the upgrade of a clean entry after a trap;
- fill overriding a same-cycle invalidate;
- duplicate tags, under random mixes of fills, invalidates and lookups.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    parameter int unsigned N_ENT   = 16;
    parameter int unsigned PAGE_W  = 20;
    parameter int unsigned FRAME_W = 20;
    localparam int unsigned IDX_W  = $clog2(N_ENT);

    typedef logic [PAGE_W-1:0]  page_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic [1:0] {
        EXC_NONE   = 2'b00,
        EXC_MISS   = 2'b01,
        EXC_WCLEAN = 2'b10
    } exc_e;

    typedef struct packed {
        logic   valid;
        logic   wr_ok;
        page_t  tag;
        frame_t frame;
    } slot_t;

    function automatic logic slot_hits(slot_t s, page_t p);
        return s.valid && (s.tag == p);
    endfunction

endpackage

// File: rtl/xlat_slot_array.sv
module xlat_slot_array
    import xlat_pkg::*;
#(
    parameter int unsigned N = N_ENT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fill_en,
    input  idx_t               fill_idx,
    input  slot_t              fill_slot,
    input  logic               inv_en,
    input  page_t              inv_page,
    output slot_t [N-1:0]      slots_o
);

    slot_t [N-1:0] slots_q;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic fill_here;
        logic inv_here;
        assign fill_here = fill_en && (fill_idx == idx_t'(i));
        assign inv_here  = inv_en && (slots_q[i].tag == inv_page);

        always_ff @(posedge clk) begin
            if (rst) begin
                slots_q[i] <= '0;
            end else if (fill_here) begin
                slots_q[i] <= fill_slot;
            end else if (inv_here) begin
                slots_q[i].valid <= 1'b0;
            end
        end

        // R9: a tag-matching entry not refilled this cycle is gone next cycle
        p_inv_clears_r9: assert property (@(posedge clk) disable iff (rst)
            (inv_en && slots_o[i].tag == inv_page &&
             !(fill_en && fill_idx == idx_t'(i))) |=> !slots_o[i].valid);
    end

    assign slots_o = slots_q;

    // R1: after a reset edge no entry is valid
    logic [N-1:0] valid_vec;
    always_comb begin
        for (int i = 0; i < N; i++) valid_vec[i] = slots_o[i].valid;
    end

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (valid_vec == '0));

    // R7: a fill appears unchanged at the addressed entry one edge later
    p_fill_lands_r7: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (slots_o[$past(fill_idx)] == $past(fill_slot)));

endmodule

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int unsigned N = N_ENT
) (
    input  logic               clk,
    input  logic               rst,
    input  slot_t [N-1:0]      slots_i,
    input  page_t              page_i,
    output logic               hit_o,
    output idx_t               sel_idx_o,
    output slot_t              sel_slot_o
);

    logic [N-1:0] hit_vec;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = slot_hits(slots_i[i], page_i);
    end

    always_comb begin
        hit_o     = 1'b0;
        sel_idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_o     = 1'b1;
                sel_idx_o = idx_t'(i);
            end
        end
    end

    assign sel_slot_o = slots_i[sel_idx_o];

    // R6: the chosen entry really matches the page
    p_pick_real_r6: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (slots_i[sel_idx_o].valid && slots_i[sel_idx_o].tag == page_i));

    // R6: no entry below the chosen one matches
    p_pick_lowest_r6: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ((hit_vec & ((N'(1) << sel_idx_o) - N'(1))) == '0));

endmodule

// File: rtl/xlat_exc_decode.sv
module xlat_exc_decode
    import xlat_pkg::*;
(
    input  logic   req_i,
    input  logic   store_i,
    input  logic   hit_i,
    input  slot_t  sel_slot_i,
    output exc_e   exc_o,
    output frame_t frame_o
);

    always_comb begin
        exc_o   = EXC_NONE;
        frame_o = '0;
        if (req_i) begin
            if (!hit_i) begin
                exc_o = EXC_MISS;
            end else if (store_i && !sel_slot_i.wr_ok) begin
                exc_o = EXC_WCLEAN;
            end else begin
                frame_o = sel_slot_i.frame;
            end
        end
    end

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lk_req,
    input  logic                      lk_store,
    input  logic [PAGE_W-1:0]         lk_page,
    output logic [FRAME_W-1:0]        lk_frame,
    output logic [1:0]                lk_exc,
    input  logic                      fill_en,
    input  logic [IDX_W-1:0]          fill_idx,
    input  logic                      fill_valid,
    input  logic                      fill_wr_ok,
    input  logic [PAGE_W-1:0]         fill_page,
    input  logic [FRAME_W-1:0]        fill_frame,
    input  logic                      inv_en,
    input  logic [PAGE_W-1:0]         inv_page
);

    slot_t [N_ENT-1:0] slots;
    slot_t             fill_slot;
    slot_t             sel_slot;
    logic              hit;
    idx_t              sel_idx;
    exc_e              exc;

    assign fill_slot = '{valid: fill_valid, wr_ok: fill_wr_ok,
                         tag: fill_page, frame: fill_frame};

    xlat_slot_array #(.N(N_ENT)) u_array (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_slot (fill_slot),
        .inv_en    (inv_en),
        .inv_page  (inv_page),
        .slots_o   (slots)
    );

    xlat_match #(.N(N_ENT)) u_match (
        .clk        (clk),
        .rst        (rst),
        .slots_i    (slots),
        .page_i     (lk_page),
        .hit_o      (hit),
        .sel_idx_o  (sel_idx),
        .sel_slot_o (sel_slot)
    );

    xlat_exc_decode u_decode (
        .req_i      (lk_req),
        .store_i    (lk_store),
        .hit_i      (hit),
        .sel_slot_i (sel_slot),
        .exc_o      (exc),
        .frame_o    (lk_frame)
    );

    assign lk_exc = exc;

    // R10: no request, no code and no frame
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !lk_req |-> (lk_exc == 2'b00 && lk_frame == '0));

    // R2: the unused code never appears
    p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
        lk_exc != 2'b11);

    // R3: loads never take the clean-page trap
    p_load_no_trap_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !lk_store) |-> (lk_exc != 2'b10));

    // R5: a clean-page trap only follows a store and hides the frame
    p_trap_is_store_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_exc == 2'b10) |-> (lk_store && lk_frame == '0 && hit));

endmodule

// File: tb/sim_xlat_buffer.sv
`timescale 1ns/1ps
module sim_xlat_buffer;
    import xlat_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic   rst, lk_req, lk_store, fill_en, fill_valid, fill_wr_ok, inv_en;
    page_t  lk_page, fill_page, inv_page;
    frame_t fill_frame, lk_frame;
    idx_t   fill_idx;
    logic [1:0] lk_exc;

    xlat_buffer u0 (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_store(lk_store),
        .lk_page(lk_page), .lk_frame(lk_frame), .lk_exc(lk_exc),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_valid(fill_valid),
        .fill_wr_ok(fill_wr_ok), .fill_page(fill_page), .fill_frame(fill_frame),
        .inv_en(inv_en), .inv_page(inv_page)
    );

    slot_t model [N_ENT];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic idle();
        lk_req = 0; lk_store = 0; lk_page = '0;
        fill_en = 0; fill_idx = '0; fill_valid = 0; fill_wr_ok = 0;
        fill_page = '0; fill_frame = '0; inv_en = 0; inv_page = '0;
    endtask

    task automatic expect_now(string rq);
        logic [1:0] e_exc;
        frame_t     e_frm;
        int         pick;
        string      tag;
        pick = -1;
        for (int i = N_ENT - 1; i >= 0; i--)
            if (model[i].valid && model[i].tag == lk_page) pick = i;
        e_exc = 2'b00; e_frm = '0;
        if (!lk_req) tag = "R10";
        else if (pick < 0) begin e_exc = 2'b01; tag = "R2"; end
        else if (lk_store && !model[pick].wr_ok) begin e_exc = 2'b10; tag = "R5"; end
        else begin e_frm = model[pick].frame; tag = lk_store ? "R4" : "R3"; end
        if (rq != "") tag = rq;
        n_chk++;
        if (lk_exc !== e_exc || lk_frame !== e_frm) begin
            n_bad++;
            $display("FAIL %s: exc=%b frame=%h expected exc=%b frame=%h",
                     tag, lk_exc, lk_frame, e_exc, e_frm);
        end
    endtask

    task automatic tick(string rq);
        #1;
        if (!rst) expect_now(rq);
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) model[i] = '0;
        end else begin
            if (inv_en)
                for (int i = 0; i < N_ENT; i++)
                    if (model[i].tag == inv_page) model[i].valid = 1'b0;
            if (fill_en)
                model[fill_idx] = '{valid: fill_valid, wr_ok: fill_wr_ok,
                                    tag: fill_page, frame: fill_frame};
        end
        @(negedge clk);
    endtask

    task automatic fill(int idx, logic v, logic w, page_t p, frame_t f);
        fill_en = 1; fill_idx = idx_t'(idx); fill_valid = v;
        fill_wr_ok = w; fill_page = p; fill_frame = f;
    endtask

    task automatic look(logic st, page_t p);
        lk_req = 1; lk_store = st; lk_page = p;
    endtask

    localparam page_t PA = 20'hABCDE;
    localparam page_t PB = 20'h00123;

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0001);
        idle();
        rst = 1;
        @(negedge clk); tick("R1"); tick("R1");
        rst = 0;
        // R1: empty after reset
        look(0, PA); tick("R1");
        look(1, 20'h0); tick("R1");
        // R7: lookup in the fill cycle sees the old (empty) entry
        idle(); fill(3, 1, 0, PA, 20'h11111); look(0, PA); tick("R7");
        // R3: load on a clean entry completes
        idle(); look(0, PA); tick("R3");
        // R5: store on a clean entry traps
        idle(); look(1, PA); tick("R5");
        // R10: no request while a store would trap
        idle(); lk_store = 1; lk_page = PA; tick("R10");
        // R8 + R7: in-place upgrade; same-cycle store still traps
        idle(); fill(3, 1, 1, PA, 20'h11111); look(1, PA); tick("R7");
        idle(); look(1, PA); tick("R8");
        // R6: duplicates, lowest index wins
        idle(); fill(7, 1, 1, PA, 20'h22222); tick("");
        idle(); fill(1, 1, 0, PA, 20'h33333); tick("");
        idle(); look(0, PA); tick("R6");
        idle(); look(1, PA); tick("R6");
        idle(); fill(0, 1, 1, PB, 20'h44444); look(0, PB); tick("R7");
        idle(); look(1, PB); tick("R4");
        // R9: invalidate all PA copies; same-cycle fill to idx 4 survives
        idle(); inv_en = 1; inv_page = PA; fill(4, 1, 1, PA, 20'h55555); tick("");
        idle(); look(1, PA); tick("R9");
        idle(); inv_en = 1; inv_page = PA; tick("");
        idle(); look(0, PA); tick("R9");
        idle(); look(0, PB); tick("R9");
        // R1: mid-run reset
        idle(); rst = 1; tick("R1");
        rst = 0; look(0, PB); tick("R1");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            idle();
            rst = ($urandom % 300) == 0;
            if ($urandom % 3 == 0)
                fill($urandom % N_ENT, ($urandom % 5) != 0, $urandom % 2,
                     20'h40000 + page_t'($urandom % 6), frame_t'($urandom));
            if ($urandom % 9 == 0) begin
                inv_en = 1; inv_page = 20'h40000 + page_t'($urandom % 6);
            end
            lk_req = ($urandom % 8) != 0;
            lk_store = $urandom % 2;
            lk_page = 20'h40000 + page_t'($urandom % 7);
            tick("");
            rst = 0;
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule